// File: doc/BRIEF.md
# Accumulator Instruction Fetch-Execute Sequencer

This block is the multi-cycle control and datapath of a small machine with a 12-bit word and one accumulator. While its run flag is set, it repeats two phases. In the fetch phase it reads the word at the program counter from a 4096-word memory into the instruction register and advances the counter. In the execute phase it carries out the word's opcode. It holds the accumulator, a one-bit link that extends the accumulator for carries, the program counter, the instruction register and the run flag. It drives one synchronous memory port. The address is registered and read data returns one cycle later. Each memory access takes its own state.

The block does not compute operand addresses. For opcodes 0 to 5 it raises an address request and waits for a separate address unit to return the effective address with a done strobe. Opcode 7 words are passed to an external micro-operation unit through a second request/done handshake. That unit returns a new accumulator and link, a skip flag and a halt flag. Opcode 6 emits up to three single-clock device pulses in a fixed order, each shown together with a 6-bit device number. After every completed instruction the block pulses an instruction-done strobe.

Top module: `accseq_top`

## Requirements
- R1: After reset the accumulator, link and program counter are 0 and `running` is low. While idle the block issues no request, memory write or device pulse. A `startIn` pulse sets `running` and begins a fetch at the current program counter.
- R2: A fetch loads the instruction register with the memory word at the program counter and increments the program counter. The opcode is instruction bits [11:9].
- R3: Opcode 0 replaces the accumulator with the bitwise AND of the accumulator and the memory word at the effective address. The link is unchanged.
- R4: Opcode 1 adds the memory word at the effective address to the 13-bit value {link, accumulator}. A carry out of bit 11 therefore toggles the link.
- R5: Opcode 2 writes back the memory word at the effective address plus one (modulo 4096). If the new value is 0, the program counter is incremented once more.
- R6: Opcode 3 writes the accumulator to the effective address and then clears the accumulator.
- R7: Opcode 4 writes the already-incremented program counter to the effective address and then sets the program counter to the effective address plus one.
- R8: Opcode 5 sets the program counter to the effective address.
- R9: Opcode 6 takes three successive cycles. In these cycles `ioPulse1`, `ioPulse2` and `ioPulse4` go high, in that order, for one clock each, gated by instruction bits 2, 1 and 0. `ioDevSel` carries instruction bits [8:3]. At most one pulse is high in any cycle.
- R10: Opcode 7 raises `opReq` and holds it until `opDone`. On `opDone` the block loads the accumulator from `opAcIn` and the link from `opLinkIn`. It increments the program counter once more if `opSkip` is set, and clears the run flag if `opHalt` is set.
- R11: `eaReq` is raised for opcodes 0 to 5 only and stays high until `eaDone`. The effective address is `eaAddr`, sampled in that cycle.
- R12: `instrDone` is high for exactly one cycle after each instruction, when all of that instruction's register and memory effects are visible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startIn | input | 1 | Sets the run flag when idle |
| memAddr | output | 12 | Memory address (registered by the memory) |
| memWrEn | output | 1 | Memory write enable |
| memWrData | output | 12 | Memory write data |
| memRdData | input | 12 | Memory read data, one cycle after the address |
| eaReq | output | 1 | Effective-address request |
| eaDone | input | 1 | Effective address valid |
| eaAddr | input | 12 | Effective address |
| opReq | output | 1 | Micro-operation request (opcode 7) |
| opDone | input | 1 | Micro-operation result valid |
| opAcIn | input | 12 | New accumulator from the micro-operation unit |
| opLinkIn | input | 1 | New link from the micro-operation unit |
| opSkip | input | 1 | Skip the next word |
| opHalt | input | 1 | Clear the run flag |
| ioPulse1 | output | 1 | First device pulse |
| ioPulse2 | output | 1 | Second device pulse |
| ioPulse4 | output | 1 | Third device pulse |
| ioDevSel | output | 6 | Device number, instruction bits [8:3] |
| instrDone | output | 1 | One-cycle instruction-complete strobe |
| running | output | 1 | Run flag |
| acOut | output | 12 | Accumulator |
| linkOut | output | 1 | Link |
| pcOut | output | 12 | Program counter |
| irOut | output | 12 | Instruction register |

## Verification
The bench targets the following corner cases, and what a faulty design would do in each:
- **Add carry.** An add whose carry leaves bit 11 must flip the link. A design that sets or ignores the link would report the wrong link after the second add of the directed program.
- **Increment-and-skip wrap.** Incrementing 7777 (octal) must both store 0 and skip. Testing the old value, or testing before write-back, would leave the program counter one short.
- **Return address.** The call opcode must store the program counter that was already advanced past the call. Storing the unadvanced value would leave an off-by-one word in memory.
- **Pulse pattern.** A device word with a gap in its pulse pattern (bits 101) shows whether the pulses keep their order and stay gated.
- **Skip and halt.** Both come from the micro-operation handshake, so the bench checks that a halt stops fetching and that a restart resumes from the right address.

// File: rtl/accseq_pkg.sv
package accseq_pkg;
  localparam int WORD_W  = 12;
  localparam int ADDR_W  = 12;
  localparam int OPC_W   = 3;
  localparam int DEV_W   = 6;
  localparam int PULSE_N = 3;
  localparam int SUM_W   = WORD_W + 1;
  localparam int DEV_LSB = PULSE_N;

  localparam logic [OPC_W-1:0] OP_MASK     = 3'd0;
  localparam logic [OPC_W-1:0] OP_ADD      = 3'd1;
  localparam logic [OPC_W-1:0] OP_INCSKIP  = 3'd2;
  localparam logic [OPC_W-1:0] OP_STORECLR = 3'd3;
  localparam logic [OPC_W-1:0] OP_CALL     = 3'd4;
  localparam logic [OPC_W-1:0] OP_JUMP     = 3'd5;
  localparam logic [OPC_W-1:0] OP_DEVICE   = 3'd6;
  localparam logic [OPC_W-1:0] OP_MICRO    = 3'd7;

  typedef enum logic [1:0] {WR_TMP, WR_AC, WR_PC} wrSel_e;

  typedef enum logic [3:0] {
    S_IDLE, S_FETCH, S_LOAD, S_DECODE, S_EA, S_RDADDR, S_RDDATA,
    S_WRITE, S_IO1, S_IO2, S_IO3, S_OPR, S_DONE
  } state_e;

  typedef struct packed {
    logic   ldIr;
    logic   incPc;
    logic   ldPcEa;
    logic   ldPcEaInc;
    logic   ldEa;
    logic   andAc;
    logic   addAc;
    logic   ldTmp;
    logic   clrAc;
    logic   ldOp;
    logic   addrEa;
    wrSel_e wrSel;
  } ctl_t;
endpackage

// File: rtl/accseq_ctrl.sv
module accseq_ctrl
  import accseq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               startIn,
  input  logic [OPC_W-1:0]   opcode,
  input  logic [PULSE_N-1:0] ioBits,
  input  logic               tmpZero,
  input  logic               eaDone,
  input  logic               opDone,
  input  logic               opSkip,
  input  logic               opHalt,
  output ctl_t               ctl,
  output logic               eaReq,
  output logic               opReq,
  output logic               memWrEn,
  output logic [PULSE_N-1:0] pulse,
  output logic               instrDone,
  output logic               running
);
  state_e state, nxt;
  logic   run;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      run   <= 1'b0;
    end else begin
      state <= nxt;
      if (state == S_IDLE && startIn) run <= 1'b1;
      else if (state == S_OPR && opDone && opHalt) run <= 1'b0;
    end
  end

  assign running = run;

  always_comb begin
    ctl       = '0;
    ctl.wrSel = WR_AC;
    nxt       = state;
    eaReq     = 1'b0;
    opReq     = 1'b0;
    memWrEn   = 1'b0;
    pulse     = '0;
    instrDone = 1'b0;
    case (state)
      S_IDLE:  if (startIn) nxt = S_FETCH;
      S_FETCH: nxt = S_LOAD;
      S_LOAD: begin
        ctl.ldIr  = 1'b1;
        ctl.incPc = 1'b1;
        nxt       = S_DECODE;
      end
      S_DECODE: begin
        if (opcode == OP_DEVICE)     nxt = S_IO1;
        else if (opcode == OP_MICRO) nxt = S_OPR;
        else                         nxt = S_EA;
      end
      S_EA: begin
        eaReq = 1'b1;
        if (eaDone) begin
          ctl.ldEa = 1'b1;
          case (opcode)
            OP_MASK, OP_ADD, OP_INCSKIP: nxt = S_RDADDR;
            OP_STORECLR, OP_CALL:        nxt = S_WRITE;
            default: begin
              ctl.ldPcEa = 1'b1;
              nxt        = S_DONE;
            end
          endcase
        end
      end
      S_RDADDR: begin
        ctl.addrEa = 1'b1;
        nxt        = S_RDDATA;
      end
      S_RDDATA: begin
        ctl.addrEa = 1'b1;
        case (opcode)
          OP_MASK: begin ctl.andAc = 1'b1; nxt = S_DONE; end
          OP_ADD:  begin ctl.addAc = 1'b1; nxt = S_DONE; end
          default: begin ctl.ldTmp = 1'b1; nxt = S_WRITE; end
        endcase
      end
      S_WRITE: begin
        ctl.addrEa = 1'b1;
        memWrEn    = 1'b1;
        nxt        = S_DONE;
        case (opcode)
          OP_INCSKIP: begin
            ctl.wrSel = WR_TMP;
            ctl.incPc = tmpZero;
          end
          OP_STORECLR: begin
            ctl.wrSel = WR_AC;
            ctl.clrAc = 1'b1;
          end
          default: begin
            ctl.wrSel     = WR_PC;
            ctl.ldPcEaInc = 1'b1;
          end
        endcase
      end
      S_IO1: begin pulse[0] = ioBits[2]; nxt = S_IO2; end
      S_IO2: begin pulse[1] = ioBits[1]; nxt = S_IO3; end
      S_IO3: begin pulse[2] = ioBits[0]; nxt = S_DONE; end
      S_OPR: begin
        opReq = 1'b1;
        if (opDone) begin
          ctl.ldOp  = 1'b1;
          ctl.incPc = opSkip;
          nxt       = S_DONE;
        end
      end
      S_DONE: begin
        instrDone = 1'b1;
        nxt       = run ? S_FETCH : S_IDLE;
      end
      default: nxt = S_IDLE;
    endcase
  end
endmodule

// File: rtl/accseq_dpath.sv
module accseq_dpath
  import accseq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctl_t              ctl,
  input  logic [WORD_W-1:0] memRdData,
  input  logic [ADDR_W-1:0] eaAddr,
  input  logic [WORD_W-1:0] opAcIn,
  input  logic              opLinkIn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWrData,
  output logic [WORD_W-1:0] ir,
  output logic [WORD_W-1:0] ac,
  output logic              link,
  output logic [ADDR_W-1:0] pc,
  output logic              tmpZero
);
  logic [ADDR_W-1:0] ea;
  logic [WORD_W-1:0] tmp;
  logic [SUM_W-1:0]  sum;

  assign sum = {link, ac} + {1'b0, memRdData};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ac   <= '0;
      link <= 1'b0;
      pc   <= '0;
      ir   <= '0;
      ea   <= '0;
      tmp  <= '0;
    end else begin
      if (ctl.ldIr) ir <= memRdData;
      if (ctl.ldEa) ea <= eaAddr;
      if (ctl.ldTmp) tmp <= memRdData + 1'b1;

      if (ctl.ldPcEa)         pc <= eaAddr;
      else if (ctl.ldPcEaInc) pc <= ea + 1'b1;
      else if (ctl.incPc)     pc <= pc + 1'b1;

      if (ctl.andAc)      ac <= ac & memRdData;
      else if (ctl.addAc) {link, ac} <= sum;
      else if (ctl.clrAc) ac <= '0;
      else if (ctl.ldOp)  {link, ac} <= {opLinkIn, opAcIn};
    end
  end

  assign tmpZero = (tmp == '0);
  assign memAddr = ctl.addrEa ? ea : pc;

  always_comb begin
    case (ctl.wrSel)
      WR_TMP:  memWrData = tmp;
      WR_PC:   memWrData = pc;
      default: memWrData = ac;
    endcase
  end
endmodule

// File: rtl/accseq_top.sv
module accseq_top
  import accseq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              startIn,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWrEn,
  output logic [WORD_W-1:0] memWrData,
  input  logic [WORD_W-1:0] memRdData,
  output logic              eaReq,
  input  logic              eaDone,
  input  logic [ADDR_W-1:0] eaAddr,
  output logic              opReq,
  input  logic              opDone,
  input  logic [WORD_W-1:0] opAcIn,
  input  logic              opLinkIn,
  input  logic              opSkip,
  input  logic              opHalt,
  output logic              ioPulse1,
  output logic              ioPulse2,
  output logic              ioPulse4,
  output logic [DEV_W-1:0]  ioDevSel,
  output logic              instrDone,
  output logic              running,
  output logic [WORD_W-1:0] acOut,
  output logic              linkOut,
  output logic [ADDR_W-1:0] pcOut,
  output logic [WORD_W-1:0] irOut
);
  ctl_t               ctl;
  logic [PULSE_N-1:0] pulse;
  logic               tmpZero;

  accseq_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .startIn(startIn),
    .opcode(irOut[WORD_W-1 -: OPC_W]), .ioBits(irOut[PULSE_N-1:0]),
    .tmpZero(tmpZero), .eaDone(eaDone), .opDone(opDone),
    .opSkip(opSkip), .opHalt(opHalt), .ctl(ctl), .eaReq(eaReq),
    .opReq(opReq), .memWrEn(memWrEn), .pulse(pulse),
    .instrDone(instrDone), .running(running)
  );

  accseq_dpath dpath_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .memRdData(memRdData),
    .eaAddr(eaAddr), .opAcIn(opAcIn), .opLinkIn(opLinkIn),
    .memAddr(memAddr), .memWrData(memWrData), .ir(irOut),
    .ac(acOut), .link(linkOut), .pc(pcOut), .tmpZero(tmpZero)
  );

  assign ioPulse1 = pulse[0];
  assign ioPulse2 = pulse[1];
  assign ioPulse4 = pulse[2];
  assign ioDevSel = irOut[DEV_LSB +: DEV_W];
endmodule

// File: rtl/accseq_chk.sv
module accseq_chk (
  input logic clk,
  input logic rstN,
  input logic eaReq,
  input logic eaDone,
  input logic opReq,
  input logic opDone,
  input logic memWrEn,
  input logic ioPulse1,
  input logic ioPulse2,
  input logic ioPulse4,
  input logic instrDone,
  input logic running
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !running |-> !(eaReq || opReq || memWrEn || ioPulse1 || ioPulse2 || ioPulse4)); // R1
  AST_WRITE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |=> !memWrEn); // R6
  AST_PULSE_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ioPulse1, ioPulse2, ioPulse4})); // R9
  AST_PULSE_FIRST_SHORT: assert property (@(posedge clk) disable iff (!rstN)
    ioPulse1 |=> !ioPulse1); // R9
  AST_PULSE_LAST_END: assert property (@(posedge clk) disable iff (!rstN)
    ioPulse4 |=> !(ioPulse1 || ioPulse2 || ioPulse4)); // R9
  AST_OP_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (opReq && !opDone) |=> opReq); // R10
  AST_EA_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (eaReq && !eaDone) |=> eaReq); // R11
  AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(eaReq && opReq)); // R11
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    instrDone |=> !instrDone); // R12
endmodule

bind accseq_top accseq_chk chk_i (
  .clk(clk), .rstN(rstN), .eaReq(eaReq), .eaDone(eaDone),
  .opReq(opReq), .opDone(opDone), .memWrEn(memWrEn),
  .ioPulse1(ioPulse1), .ioPulse2(ioPulse2), .ioPulse4(ioPulse4),
  .instrDone(instrDone), .running(running)
);

// File: tb/accseq_top_tb_top.sv
`timescale 1ns/1ps
module accseq_top_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startIn = 1'b0;
  logic [11:0] memAddr, memWrData, memRdData;
  logic        memWrEn;
  logic        eaReq, opReq;
  logic        eaDone = 1'b0, opDone = 1'b0;
  logic [11:0] eaAddr = '0, opAcIn = '0;
  logic        opLinkIn = 1'b0, opSkip = 1'b0, opHalt = 1'b0;
  logic        ioPulse1, ioPulse2, ioPulse4;
  logic [5:0]  ioDevSel;
  logic        instrDone, running, linkOut;
  logic [11:0] acOut, pcOut, irOut;

  always #4 clk = ~clk;

  accseq_top dut_i (.*);

  // bench memory with a loader port
  logic [11:0] ram [0:4095];
  logic        ldEn = 1'b0;
  logic [11:0] ldA = '0, ldD = '0;
  always @(posedge clk) begin
    if (ldEn) ram[ldA] <= ldD;
    else if (memWrEn) ram[memAddr] <= memWrData;
    memRdData <= ram[memAddr];
  end

  // address unit and micro-operation unit responders
  int  eaWait = 0, opWait = 0;
  bit  allowHalt = 1'b1;
  always @(negedge clk) begin
    eaDone = 1'b0;
    opDone = 1'b0;
    if (eaReq) begin
      if (eaWait == 0) begin
        eaDone = 1'b1;
        eaAddr = {5'b0, irOut[6:0]};
        eaWait = $urandom % 3;
      end else eaWait = eaWait - 1;
    end
    if (opReq) begin
      if (opWait == 0) begin
        opDone   = 1'b1;
        opAcIn   = ~acOut;
        opLinkIn = linkOut ^ irOut[3];
        opSkip   = irOut[0];
        opHalt   = allowHalt && (irOut == 12'o7402);
        opWait   = $urandom % 3;
      end else opWait = opWait - 1;
    end
  end

  // reference model
  logic [11:0] mMem [0:4095];
  logic [11:0] mAc, mPc, mIr, mEa;
  logic        mL, mRun;
  int checks = 0, fails = 0;
  bit aborted = 1'b0;

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic put(input logic [11:0] a, input logic [11:0] d);
    mMem[a] = d;
    ldEn = 1'b1; ldA = a; ldD = d;
    @(negedge clk);
    ldEn = 1'b0;
  endtask

  task automatic fillAll(input bit rnd);
    for (int a = 0; a < 4096; a++) put(a[11:0], rnd ? 12'($urandom) : 12'h000);
  endtask

  function automatic string opTag(input logic [2:0] op);
    case (op)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return "R6";
      3'd4: return "R7";
      3'd5: return "R8";
      3'd6: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic modelStep();
    logic [12:0] s;
    mIr = mMem[mPc];
    mPc = mPc + 1;
    mEa = {5'b0, mIr[6:0]};
    case (mIr[11:9])
      3'd0: mAc = mAc & mMem[mEa];
      3'd1: begin s = {mL, mAc} + {1'b0, mMem[mEa]}; mL = s[12]; mAc = s[11:0]; end
      3'd2: begin mMem[mEa] = mMem[mEa] + 1; if (mMem[mEa] == 0) mPc = mPc + 1; end
      3'd3: begin mMem[mEa] = mAc; mAc = '0; end
      3'd4: begin mMem[mEa] = mPc; mPc = mEa + 1; end
      3'd5: mPc = mEa;
      3'd6: ;
      default: begin
        mAc = ~mAc;
        mL  = mL ^ mIr[3];
        if (mIr[0]) mPc = mPc + 1;
        if (allowHalt && mIr == 12'o7402) mRun = 1'b0;
      end
    endcase
  endtask

  task automatic startPulse();
    startIn = 1'b1;
    @(negedge clk);
    startIn = 1'b0;
    mRun = 1'b1;
  endtask

  task automatic runInstr(input int n, input bit stopOnHalt);
    for (int i = 0; i < n && !aborted; i++) begin
      int cnt = 0;
      logic [8:0] pl = '0, ex = '0;
      logic [5:0] dev = '0;
      bit eaSeen = 1'b0;
      string t;
      while (!instrDone && cnt < 200) begin
        if (ioPulse1 || ioPulse2 || ioPulse4) begin
          pl  = {pl[5:0], ioPulse4, ioPulse2, ioPulse1};
          dev = ioDevSel;
        end
        if (eaReq) eaSeen = 1'b1;
        @(negedge clk);
        cnt++;
      end
      if (!instrDone) begin
        check("R12", "watchdog instrDone", 0, 1);
        aborted = 1'b1;
        break;
      end
      modelStep();
      t = opTag(mIr[11:9]);
      check("R2", "ir", irOut, mIr);
      check(t, "ac", acOut, mAc);
      check(t, "link", linkOut, mL);
      check(t, "pc", pcOut, mPc);
      if (mIr[11:9] inside {3'd2, 3'd3, 3'd4}) check(t, "mem[ea]", ram[mEa], mMem[mEa]);
      check("R11", "eaReq seen", eaSeen, (mIr[11:9] <= 3'd5));
      if (mIr[2]) ex = {ex[5:0], 3'b001};
      if (mIr[1]) ex = {ex[5:0], 3'b010};
      if (mIr[0]) ex = {ex[5:0], 3'b100};
      if (mIr[11:9] != 3'd6) ex = '0;
      check("R9", "pulse order", pl, ex);
      if (ex != 0) check("R9", "devSel", dev, mIr[8:3]);
      @(negedge clk);
      check("R12", "instrDone width", instrDone, 0);
      if (!mRun) begin
        check("R10", "halt clears running", running, 0);
        if (stopOnHalt) break;
        startPulse();
      end
    end
  endtask

  initial begin
    void'($urandom(32'h1234_5eed));
    // directed program (octal), EA = low 7 bits of the word
    fillAll(1'b0);
    put(12'o0000, 12'o1100);  // add 7777
    put(12'o0001, 12'o1101);  // add 0001: carry toggles link
    put(12'o0002, 12'o2102);  // 7777 -> 0, skip
    put(12'o0003, 12'o7000);
    put(12'o0004, 12'o2103);  // 5 -> 6, no skip
    put(12'o0005, 12'o1100);
    put(12'o0006, 12'o0104);  // and 5252
    put(12'o0007, 12'o3105);  // store and clear
    put(12'o0010, 12'o4110);  // call 0110
    put(12'o0111, 12'o6545);  // device 54, pulses 1 and 4
    put(12'o0112, 12'o7001);  // micro with skip
    put(12'o0114, 12'o5120);  // jump 0120
    put(12'o0120, 12'o7402);  // halt
    put(12'o0100, 12'o7777);
    put(12'o0101, 12'o0001);
    put(12'o0102, 12'o7777);
    put(12'o0103, 12'o0005);
    put(12'o0104, 12'o5252);
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    mAc = '0; mL = 1'b0; mPc = '0; mRun = 1'b0;
    check("R1", "reset ac", acOut, 0);
    check("R1", "reset link", linkOut, 0);
    check("R1", "reset pc", pcOut, 0);
    check("R1", "reset running", running, 0);
    check("R12", "reset instrDone", instrDone, 0);
    repeat (3) @(negedge clk);
    check("R1", "idle pc held", pcOut, 0);
    startPulse();
    check("R1", "start sets running", running, 1);
    runInstr(20, 1'b1);
    repeat (5) @(negedge clk);
    check("R10", "halted stays idle", running, 0);
    check("R10", "halted pc stable", pcOut, 12'o0121);
    check("R7", "return word", ram[12'o0110], 12'o0011);
    check("R5", "wrapped word", ram[12'o0102], 0);

    // random programs
    rstN = 1'b0;
    fillAll(1'b1);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    mAc = '0; mL = 1'b0; mPc = '0; mRun = 1'b0;
    check("R1", "reset pc (random phase)", pcOut, 0);
    if (!aborted) begin
      startPulse();
      runInstr(1500, 1'b0);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule